// File: doc/BRIEF.md
# Toggle-Handshake Process Data Interface

This block sits on the terminal side of a word-oriented exchange between a host controller and a pair of serial byte FIFOs. Each cycle the host presents a 16-bit control word and an area of up to 22 outgoing bytes. The block returns a 16-bit status word and an area of up to 22 incoming bytes. Every request and every acknowledgement is signalled by inverting one bit of a word, never by a level or a pulse. Byte counts travel in the upper byte of each word.

When the host inverts its transmit-request bit, the block copies the offered bytes into the transmit FIFO one per cycle. It then inverts its transmit-acknowledge bit. On the other side, bytes that the serial engine pushes into the receive FIFO are gathered into the incoming area in chunks of at most 22. The block writes the chunk's count and inverts its receive-request bit, then waits until the host inverts its receive-accepted bit before it gathers the next chunk. A level-held initialization request empties both FIFOs, halts the serial side and is answered by an acknowledge bit.

Top module: `pdx_handshake`

## Requirements
- R1: After reset the status word is 0 (bits 7:4 of the status word always read 0), `serial_en_o` is 1 and `tx_empty_o` is 1.
- R2: An inversion of control bit 0 with a byte count N in control bits 15:8, 1 ≤ N ≤ 22, and room for N bytes pushes bytes 0..N-1 into the transmit FIFO in order. Byte k is `out_bytes_i[8k+7:8k]`. After the last byte is pushed, status bit 0 inverts.
- R3: A transmit request with a count of 0 or above 22 inverts status bit 0 and pushes no byte.
- R4: If the transmit FIFO has fewer free places than N, status bit 3 (buffer full) is set and status bit 0 is held. Once room appears, the bytes are pushed, bit 3 clears and bit 0 inverts.
- R5: An inversion of control bit 0 while an earlier request is still unacknowledged is ignored.
- R6: When the receive FIFO holds data and no delivery is outstanding, the block moves up to 22 bytes into `in_bytes_o` (byte k at bits 8k+7:8k), writes their count to status bits 15:8 and inverts status bit 1.
- R7: After a delivery, no further delivery happens until control bit 1 is inverted.
- R8: While control bit 2 is 1, both FIFOs are emptied and status bits 15:8 are cleared. Status bit 2 is 1 from the next cycle on, `serial_en_o` is 0 while status bit 2 is 1, and any outstanding delivery is dropped.
- R9: Inversions of control bits 0 and 1 made during initialization are ignored and cause no event when control bit 2 returns to 0. Status bit 2 clears the cycle after control bit 2 returns to 0.
- R10: While control bit 7 is 1 or any of control bits 6:3 is 1, inversions of control bits 0 and 1 are ignored.
- R11: A transmit request and a receive acceptance inverted in the same control word are both served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_word_i | input | 16 | Control word from the host |
| out_bytes_i | input | 176 | Host-to-terminal byte area, byte k at bits 8k+7:8k |
| stat_word_o | output | 16 | Status word to the host |
| in_bytes_o | output | 176 | Terminal-to-host byte area, byte k at bits 8k+7:8k |
| serial_en_o | output | 1 | Serial side enabled (low during initialization) |
| tx_pop_i | input | 1 | Serial engine takes the transmit FIFO head |
| tx_data_o | output | 8 | Transmit FIFO head byte |
| tx_empty_o | output | 1 | Transmit FIFO is empty |
| rx_push_i | input | 1 | Serial engine offers a received byte |
| rx_data_i | input | 8 | Received byte |

## Verification
The transmit copy and the receive delivery run as separate engines on separate FIFOs, so a transmit request and a receive acceptance can land on the same clock edge. The bench provokes this by inverting control bits 0 and 1 in one control-word write while two received bytes wait behind an unaccepted delivery. It then requires both status bits 0 and 1 to invert. The scoreboard must receive the four transmit bytes in order, and the incoming area must carry exactly the two waiting bytes with a count of 2.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_MOVE} tx_state_e;
  typedef enum logic       {RX_IDLE, RX_MOVE}          rx_state_e;

  localparam int unsigned TR_BIT   = 0;
  localparam int unsigned RA_BIT   = 1;
  localparam int unsigned IR_BIT   = 2;
  localparam int unsigned LEN_LSB  = 8;
  localparam int unsigned LEN_W    = 8;
endpackage

// File: rtl/pdx_toggle_det.sv
module pdx_toggle_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] bits_i,
  input  logic         hold_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] prev_q;

  // the copy always tracks, so leaving hold resynchronizes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= bits_i;
  end

  assign evt_o = hold_i ? '0 : (bits_i ^ prev_q);
endmodule

// File: rtl/pdx_byte_fifo.sv
module pdx_byte_fifo #(
  parameter  int unsigned W     = 8,
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_i) wr_d = wr_q + AW'(1);
      if (pop_i)  rd_d = rd_q + AW'(1);
      cnt_d = cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem[wr_q] <= din_i;
  end

  assign dout_o  = mem[rd_q];
  assign count_o = cnt_q;

  // R2: callers never push into a full store
  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q != CW'(DEPTH)));
  // R6: callers never pop an empty store
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/pdx_handshake.sv
module pdx_handshake
  import pdx_pkg::*;
#(
  parameter  int unsigned W          = 8,
  parameter  int unsigned MAX_BYTES  = 22,
  parameter  int unsigned FIFO_DEPTH = 32,
  localparam int unsigned IW         = $clog2(MAX_BYTES + 1),
  localparam int unsigned CW         = $clog2(FIFO_DEPTH) + 1,
  localparam int unsigned AREA_W     = MAX_BYTES * W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       ctrl_word_i,
  input  logic [AREA_W-1:0] out_bytes_i,
  output logic [15:0]       stat_word_o,
  output logic [AREA_W-1:0] in_bytes_o,
  output logic              serial_en_o,
  input  logic              tx_pop_i,
  output logic [W-1:0]      tx_data_o,
  output logic              tx_empty_o,
  input  logic              rx_push_i,
  input  logic [W-1:0]      rx_data_i
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BYTES);
  localparam logic [IW-1:0]    MAX_IDX = IW'(MAX_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // control word decode
  logic             init_req, mode_ok, hold;
  logic [LEN_W-1:0] req_len;
  logic             len_ok;
  logic [1:0]       evt;
  logic             tr_evt, ra_evt;

  assign init_req = ctrl_word_i[IR_BIT];
  assign mode_ok  = (ctrl_word_i[7:3] == 5'b0);
  assign hold     = init_req | ~mode_ok;
  assign req_len  = ctrl_word_i[LEN_LSB +: LEN_W];
  assign len_ok   = (req_len != '0) && (req_len <= MAX_LEN);

  pdx_toggle_det #(.N(2)) u_tog (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .bits_i ({ctrl_word_i[RA_BIT], ctrl_word_i[TR_BIT]}),
    .hold_i (hold),
    .evt_o  (evt)
  );
  assign tr_evt = evt[0];
  assign ra_evt = evt[1];

  // FIFOs
  logic          tx_push, tx_pop, rx_push, rx_pop;
  logic [W-1:0]  tx_din, rx_dout;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic          tx_full, rx_full, rx_empty;

  assign tx_full    = (tx_cnt == CW'(FIFO_DEPTH));
  assign tx_empty_o = (tx_cnt == '0);
  assign rx_full    = (rx_cnt == CW'(FIFO_DEPTH));
  assign rx_empty   = (rx_cnt == '0);
  assign tx_free    = CW'(FIFO_DEPTH) - tx_cnt;
  assign tx_pop     = tx_pop_i & ~init_req & ~tx_empty_o;
  assign rx_push    = rx_push_i & ~init_req & ~rx_full;

  pdx_byte_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i (clk_i), .rst_ni (rst_n), .flush_i (init_req),
    .push_i (tx_push), .din_i (tx_din), .pop_i (tx_pop),
    .dout_o (tx_data_o), .count_o (tx_cnt)
  );
  pdx_byte_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i (clk_i), .rst_ni (rst_n), .flush_i (init_req),
    .push_i (rx_push), .din_i (rx_data_i), .pop_i (rx_pop),
    .dout_o (rx_dout), .count_o (rx_cnt)
  );

  function automatic logic has_room(input logic [CW-1:0] free, input logic [IW-1:0] need);
    return {{(32-CW){1'b0}}, free} >= {{(32-IW){1'b0}}, need};
  endfunction

  // transmit engine
  tx_state_e     tx_st_q, tx_st_d;
  logic [IW-1:0] tx_len_q, tx_len_d, tx_idx_q, tx_idx_d;
  logic          ta_q, ta_d, bf_q, bf_d;

  assign tx_din = out_bytes_i[int'(tx_idx_q) * W +: W];

  always_comb begin
    tx_st_d  = tx_st_q;
    tx_len_d = tx_len_q;
    tx_idx_d = tx_idx_q;
    ta_d     = ta_q;
    bf_d     = bf_q;
    tx_push  = 1'b0;
    if (init_req) begin
      tx_st_d  = TX_IDLE;
      tx_idx_d = '0;
      bf_d     = 1'b0;
    end else begin
      unique case (tx_st_q)
        TX_IDLE: if (tr_evt) begin
          if (!len_ok) begin
            ta_d = ~ta_q;
          end else begin
            tx_len_d = req_len[IW-1:0];
            tx_idx_d = '0;
            if (has_room(tx_free, req_len[IW-1:0])) tx_st_d = TX_MOVE;
            else begin
              tx_st_d = TX_WAIT;
              bf_d    = 1'b1;
            end
          end
        end
        TX_WAIT: if (has_room(tx_free, tx_len_q)) begin
          tx_st_d = TX_MOVE;
          bf_d    = 1'b0;
        end
        TX_MOVE: begin
          tx_push  = 1'b1;
          tx_idx_d = tx_idx_q + IW'(1);
          if (tx_idx_q == tx_len_q - IW'(1)) begin
            ta_d    = ~ta_q;
            tx_st_d = TX_IDLE;
          end
        end
        default: tx_st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      tx_st_q  <= TX_IDLE;
      tx_len_q <= '0;
      tx_idx_q <= '0;
      ta_q     <= 1'b0;
      bf_q     <= 1'b0;
    end else begin
      tx_st_q  <= tx_st_d;
      tx_len_q <= tx_len_d;
      tx_idx_q <= tx_idx_d;
      ta_q     <= ta_d;
      bf_q     <= bf_d;
    end
  end

  // receive engine
  rx_state_e        rx_st_q, rx_st_d;
  logic [IW-1:0]    rx_idx_q, rx_idx_d;
  logic [LEN_W-1:0] il_q, il_d;
  logic             rr_q, rr_d, wait_q, wait_d;
  logic [W-1:0]     in_buf_q [MAX_BYTES];

  always_comb begin
    rx_st_d  = rx_st_q;
    rx_idx_d = rx_idx_q;
    il_d     = il_q;
    rr_d     = rr_q;
    wait_d   = wait_q;
    rx_pop   = 1'b0;
    if (init_req) begin
      rx_st_d  = RX_IDLE;
      rx_idx_d = '0;
      il_d     = '0;
      wait_d   = 1'b0;
    end else begin
      if (ra_evt) wait_d = 1'b0;
      unique case (rx_st_q)
        RX_IDLE: if (!wait_q && !rx_empty) begin
          rx_st_d  = RX_MOVE;
          rx_idx_d = '0;
        end
        RX_MOVE: begin
          if (rx_empty || rx_idx_q == MAX_IDX) begin
            il_d    = LEN_W'(rx_idx_q);
            rr_d    = ~rr_q;
            wait_d  = 1'b1;
            rx_st_d = RX_IDLE;
          end else begin
            rx_pop   = 1'b1;
            rx_idx_d = rx_idx_q + IW'(1);
          end
        end
        default: rx_st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      rx_st_q  <= RX_IDLE;
      rx_idx_q <= '0;
      il_q     <= '0;
      rr_q     <= 1'b0;
      wait_q   <= 1'b0;
    end else begin
      rx_st_q  <= rx_st_d;
      rx_idx_q <= rx_idx_d;
      il_q     <= il_d;
      rr_q     <= rr_d;
      wait_q   <= wait_d;
    end
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n)                                  in_buf_q[g] <= '0;
      else if (rx_pop && rx_idx_q == IW'(g))       in_buf_q[g] <= rx_dout;
    end
    assign in_bytes_o[g*W +: W] = in_buf_q[g];
  end

  // init acknowledge
  logic ia_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ia_q <= 1'b0;
    else        ia_q <= init_req;
  end

  assign serial_en_o = ~ia_q;
  assign stat_word_o = {il_q, 4'b0000, bf_q, ia_q, rr_q, ta_q};

  // R8: acknowledge follows the request one cycle later
  a_r8_ia_follows: assert property (@(posedge clk_i) disable iff (!rst_n)
    init_req |=> ia_q);
  // R9: no transmit acknowledge while initializing
  a_r9_ta_still_in_init: assert property (@(posedge clk_i) disable iff (!rst_n)
    init_req |=> $stable(ta_q));
  // R4: a push never meets a full transmit FIFO
  a_r4_push_has_room: assert property (@(posedge clk_i) disable iff (!rst_n)
    tx_push |-> !tx_full);
  // R4: acknowledge is withheld while buffer-full is shown
  a_r4_full_holds_ack: assert property (@(posedge clk_i) disable iff (!rst_n)
    bf_q |=> $stable(ta_q));
  // R7: a delivery only starts when none is outstanding
  a_r7_rr_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rr_q != $past(rr_q)) |-> !$past(wait_q));
  // R6: delivered count stays within the area
  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_n)
    il_q <= MAX_LEN);
endmodule

// File: tb/tb_pdx_handshake.sv
module tb_pdx_handshake;
  localparam int NB = 22;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [15:0]     ctrl = '0;
  logic [NB*8-1:0] ob = '0;
  logic [15:0]     sw;
  logic [NB*8-1:0] ib;
  logic            sen, tx_pop = 1'b0, tx_empty, rx_push = 1'b0;
  logic [7:0]      tx_data, rx_data = '0;

  pdx_handshake dut (
    .clk_i (clk), .rst_ni (rst_n), .ctrl_word_i (ctrl), .out_bytes_i (ob),
    .stat_word_o (sw), .in_bytes_o (ib), .serial_en_o (sen),
    .tx_pop_i (tx_pop), .tx_data_o (tx_data), .tx_empty_o (tx_empty),
    .rx_push_i (rx_push), .rx_data_i (rx_data)
  );

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  bit drain = 1'b0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  logic tr = 0, ra = 0, ir = 0, md = 0;
  logic [7:0] len = 0;
  logic exp_ta = 0, exp_rr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive();
    @(negedge clk);
    ctrl = {len, md, 4'b0000, ir, ra, tr};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor for the transmit FIFO
  always @(negedge clk) begin
    if (drain && !tx_empty) begin
      if (tx_q.size() == 0) chk(0, "R2 unexpected tx byte", tx_data, 0);
      else begin
        logic [7:0] e;
        e = tx_q.pop_front();
        chk(tx_data == e, "R2 tx byte order", tx_data, e);
      end
      tx_pop = 1'b1;
    end else tx_pop = 1'b0;
  end

  task automatic send_tx(input int n, input int seed, input bit also_ra);
    for (int k = 0; k < NB; k++) ob[k*8 +: 8] = 8'(seed + 7*k);
    if (n >= 1 && n <= NB)
      for (int k = 0; k < n; k++) tx_q.push_back(8'(seed + 7*k));
    len = 8'(n);
    tr = ~tr;
    if (also_ra) ra = ~ra;
    drive();
  endtask

  task automatic wait_ta(input string tag);
    int t;
    exp_ta = ~exp_ta;
    t = 0;
    while (sw[0] != exp_ta && t < 300) begin @(negedge clk); t++; end
    chk(sw[0] == exp_ta, tag, sw[0], exp_ta);
  endtask

  task automatic rx_feed(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_push = 1'b1;
      rx_data = 8'(seed + 3*k);
      rx_q.push_back(8'(seed + 3*k));
    end
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic rx_expect(input int n, input string tag);
    int t;
    exp_rr = ~exp_rr;
    t = 0;
    while (sw[1] != exp_rr && t < 300) begin @(negedge clk); t++; end
    chk(sw[1] == exp_rr, tag, sw[1], exp_rr);
    chk(int'(sw[15:8]) == n, tag, sw[15:8], n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = (rx_q.size() != 0) ? rx_q.pop_front() : 8'hxx;
      chk(ib[k*8 +: 8] == e, tag, ib[k*8 +: 8], e);
    end
  endtask

  task automatic ack_rx();
    ra = ~ra;
    drive();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk(sw == 16'h0, "R1 status", sw, 0);
    chk(sen == 1'b1, "R1 serial_en", sen, 1);
    chk(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);

    // R2 normal transfers
    drain = 1'b1;
    send_tx(5, 8'h10, 0);  wait_ta("R2 ack len5");
    send_tx(22, 8'h40, 0); wait_ta("R2 ack len22");
    send_tx(1, 8'h90, 0);  wait_ta("R2 ack len1");
    idle(10);
    chk(tx_q.size() == 0, "R2 all bytes out", tx_q.size(), 0);

    // R3 invalid lengths
    send_tx(0, 8'h01, 0);  wait_ta("R3 ack len0");
    send_tx(23, 8'h02, 0); wait_ta("R3 ack len23");
    idle(10);
    chk(tx_empty == 1'b1, "R3 no bytes", tx_empty, 1);

    // R4 / R5 buffer full and ignored second request
    drain = 1'b0;
    send_tx(22, 8'h20, 0); wait_ta("R4 first fill");
    send_tx(20, 8'h60, 0);
    idle(10);
    chk(sw[3] == 1'b1, "R4 buffer full", sw[3], 1);
    chk(sw[0] == exp_ta, "R4 ack withheld", sw[0], exp_ta);
    tr = ~tr; drive();                       // R5 extra request while pending
    idle(5);
    drain = 1'b1;
    wait_ta("R4 ack after room");
    chk(sw[3] == 1'b0, "R4 full cleared", sw[3], 0);
    idle(60);
    chk(sw[0] == exp_ta, "R5 no second ack", sw[0], exp_ta);
    chk(tx_q.size() == 0 && tx_empty, "R5 no extra bytes", tx_q.size(), 0);

    // R6 / R7 deliveries
    rx_feed(3, 8'hA0);   rx_expect(3, "R6 small chunk");
    rx_feed(25, 8'h30);
    idle(40);
    chk(sw[1] == exp_rr, "R7 held until accept", sw[1], exp_rr);
    ack_rx();            rx_expect(22, "R6 max chunk");
    ack_rx();            rx_expect(3, "R6 remainder");

    // R11 same-cycle transmit request and receive accept
    rx_feed(2, 8'hC0);
    idle(10);
    chk(sw[1] == exp_rr, "R11 pending before accept", sw[1], exp_rr);
    send_tx(4, 8'h70, 1);
    wait_ta("R11 ta");
    rx_expect(2, "R11 rr");
    ack_rx();
    idle(10);
    chk(tx_q.size() == 0, "R11 tx bytes", tx_q.size(), 0);

    // R10 register mode and reserved bits ignore toggles
    md = 1'b1; tr = ~tr; drive();
    idle(20);
    chk(sw[0] == exp_ta, "R10 mode bit", sw[0], exp_ta);
    md = 1'b0; drive();
    idle(20);
    chk(sw[0] == exp_ta, "R10 no event on return", sw[0], exp_ta);
    tr = ~tr; drive(); ctrl[4] = 1'b1;
    idle(20);
    chk(sw[0] == exp_ta, "R10 reserved bit", sw[0], exp_ta);
    drive();
    idle(5);

    // R8 / R9 initialization
    drain = 1'b0;
    send_tx(4, 8'h55, 0); wait_ta("R8 preload");
    rx_feed(2, 8'h11); rx_expect(2, "R8 preload rx");
    rx_feed(3, 8'h22);
    ir = 1'b1; drive();
    @(negedge clk);
    chk(sw[2] == 1'b1, "R8 init ack", sw[2], 1);
    chk(sen == 1'b0, "R8 serial off", sen, 0);
    chk(tx_empty == 1'b1, "R8 tx flushed", tx_empty, 1);
    chk(sw[15:8] == 8'h0, "R8 count cleared", sw[15:8], 0);
    tx_q.delete(); rx_q.delete();
    tr = ~tr; ra = ~ra; drive();
    idle(5);
    ir = 1'b0; drive();
    @(negedge clk);
    chk(sw[2] == 1'b0, "R9 init ack drop", sw[2], 0);
    idle(20);
    chk(sw[0] == exp_ta, "R9 no stale tr", sw[0], exp_ta);
    chk(sw[1] == exp_rr, "R9 no stale rx", sw[1], exp_rr);
    chk(tx_empty == 1'b1, "R9 tx stays empty", tx_empty, 1);
    rx_feed(2, 8'hE0); rx_expect(2, "R8 delivery after init");
    drain = 1'b1;
    send_tx(3, 8'h33, 0); wait_ta("R9 transfer after init");
    idle(10);
    chk(tx_q.size() == 0, "R9 bytes after init", tx_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule